// File: doc/BRIEF.md
# Interrupt Pin Request and End-of-Interrupt Engine

This block sits between a set of raw interrupt input wires and an interrupt delivery fabric. Each pin has a routing entry (vector, destination, destination mode, delivery mode, polarity, trigger mode and mask). The entries are held by a separate register path and presented to this block as flat buses. The engine keeps a pending bit and a remote-pending flag for every pin. It turns changes on the raw wires into delivery requests under edge or level rules. It flags requests that could not be serviced as coalesced. It also accepts end-of-interrupt (EOI) messages that carry a vector number.

An EOI is acted on only if its vector is in a 256-entry filter of the vectors currently programmed. The filter is rebuilt by a small state machine after reset and after every table-change notice: FLT_WIPE clears a shadow copy and always goes to FLT_SCAN. FLT_SCAN adds one pin's vector per cycle and goes to FLT_COMMIT after the last pin. FLT_COMMIT copies the shadow into the live filter and goes to FLT_IDLE. FLT_IDLE waits. A table-change notice forces FLT_WIPE from any state.

Pins that need service queue a request bit. A fixed-priority picker issues one registered delivery per cycle, lowest pin first.

Top module: `irq_route_engine`

## Requirements
- R1: While reset is asserted and until the first input event after it, `dlv_valid`, `coalesce_pulse` and `ack_pulse` stay 0. All pending and remote-pending state starts clear.
- R2: Only a change of a pin's raw wire is an input event. The effective level is the raw level XOR the entry's polarity bit (polarity 1 = active low). An event with effective level 0 clears the pin's pending bit.
- R3: On an event with effective level 1 on an edge pin (trigger bit 0) whose pending bit was 0, the pin is serviced. If unmasked, `dlv_valid` pulses for one cycle two clock edges after the wire change is sampled. The pulse carries the entry's vector, destination, destination mode, delivery mode, trigger bit and the pin number.
- R4: On an event with effective level 1 on a level pin (trigger bit 1), the pin is serviced only if its remote-pending flag is 0. Servicing an unmasked level pin sets remote-pending.
- R5: Servicing a masked pin (mask bit 1) issues no delivery, sets no remote-pending and raises no coalesced pulse.
- R6: An accepted EOI with `eoi_level`=1 clears remote-pending on every pin whose vector equals `eoi_vector`. Each such pin that is unmasked with its pending bit set is serviced again.
- R7: An accepted EOI with `eoi_level`=0 leaves remote-pending unchanged and causes no delivery.
- R8: For every accepted EOI, `ack_pulse[i]` is 1 for one cycle on each pin i whose vector matches, whatever `eoi_level` is.
- R9: An EOI whose vector is not in the live filter is ignored: no ack, no change of state. The live filter is replaced NPINS+2 cycles after a table-change notice or reset, through FLT_WIPE, FLT_SCAN, FLT_COMMIT and FLT_IDLE.
- R10: A table-change notice with `tbl_upd_low`=1 clears the noticed pin's remote-pending. After a notice of either half, a level pin whose pending bit is set is serviced.
- R11: A delivery from pin 0 always carries destination 0 and destination mode 0 (physical), whatever its entry holds.
- R12: When several pins wait for delivery, the lowest-numbered one goes first, one per cycle; the others keep waiting.
- R13: An effective-level-1 event that is not serviced under the edge or level rule pulses `coalesce_pulse[i]` for one cycle, one edge after the change is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | NPINS | Raw interrupt wire levels |
| tbl_vector | input | NPINS*VEC_W | Vector of each entry, pin i at bits i*VEC_W |
| tbl_dest | input | NPINS*DEST_W | Destination of each entry |
| tbl_dest_mode | input | NPINS | Destination mode per entry (0 physical, 1 logical) |
| tbl_deliv | input | NPINS*3 | Delivery mode per entry |
| tbl_polarity | input | NPINS | 1 = active-low pin |
| tbl_trig | input | NPINS | 1 = level-triggered, 0 = edge-triggered |
| tbl_mask | input | NPINS | 1 = masked |
| tbl_upd | input | 1 | One-cycle notice that an entry was written |
| tbl_upd_pin | input | PIN_W | Pin whose entry was written |
| tbl_upd_low | input | 1 | The written half was the low half |
| eoi_valid | input | 1 | One-cycle EOI message strobe |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| eoi_level | input | 1 | EOI trigger mode (1 level, 0 edge) |
| dlv_valid | output | 1 | Delivery request, one cycle |
| dlv_vector | output | VEC_W | Delivered vector |
| dlv_dest | output | DEST_W | Delivered destination |
| dlv_dest_mode | output | 1 | Delivered destination mode |
| dlv_deliv | output | 3 | Delivered delivery mode |
| dlv_trig | output | 1 | Trigger mode of the delivered pin |
| dlv_pin | output | PIN_W | Pin number of the delivery |
| coalesce_pulse | output | NPINS | Per-pin coalesced-request pulse |
| ack_pulse | output | NPINS | Per-pin EOI match pulse |

## Verification
The assertions assume that no EOI or table-change notice for a pin arrives in the same cycle that the pin's delivery is issued. They also assume an entry's mask does not change between a service decision and the grant that follows it. The bench keeps within these limits: it leaves several idle cycles after each wire change, notice or EOI before it applies the next stimulus, and it changes table contents only through notices that are followed by a wait longer than the filter rebuild. Raw wires are driven half a cycle away from the active edge, so each change is sampled exactly once.

// File: rtl/ire_pkg.sv
package ire_pkg;
    typedef enum logic [1:0] {
        FLT_WIPE   = 2'd0,
        FLT_SCAN   = 2'd1,
        FLT_COMMIT = 2'd2,
        FLT_IDLE   = 2'd3
    } flt_state_e;

    localparam int DELIV_W = 3;
endpackage

// File: rtl/ire_pin_lane.sv
module ire_pin_lane #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic             pol,
    input  logic             trig_lvl,
    input  logic             mask,
    input  logic [VEC_W-1:0] vec,
    input  logic             upd_hit,
    input  logic             upd_low,
    input  logic             eoi_ok,
    input  logic [VEC_W-1:0] eoi_vec,
    input  logic             eoi_level,
    input  logic             grant,
    output logic             svc_req,
    output logic             coal_pulse,
    output logic             ack_pulse
);
    logic raw_q, pend_q, rpend_q, svc_q, coal_q, ack_q;
    logic pend_d, rpend_d, serve, coal_d, ack_d;

    always_comb begin
        pend_d  = pend_q;
        rpend_d = rpend_q;
        serve   = 1'b0;
        coal_d  = 1'b0;
        ack_d   = 1'b0;
        // low-half write drops the remote-pending flag first
        if (upd_hit && upd_low) begin
            rpend_d = 1'b0;
        end
        // raw wire event
        if (raw != raw_q) begin
            if (!(raw ^ pol)) begin
                pend_d = 1'b0;
            end else begin
                if (trig_lvl ? !rpend_d : !pend_d) begin
                    if (!mask) begin
                        serve = 1'b1;
                        if (trig_lvl) begin
                            rpend_d = 1'b1;
                        end
                    end
                end else begin
                    coal_d = 1'b1;
                end
                pend_d = 1'b1;
            end
        end
        // end-of-interrupt matched on this entry's vector
        if (eoi_ok && (vec == eoi_vec)) begin
            ack_d = 1'b1;
            if (eoi_level) begin
                rpend_d = 1'b0;
                if (!mask && pend_d) begin
                    serve = 1'b1;
                    if (trig_lvl) begin
                        rpend_d = 1'b1;
                    end
                end
            end
        end
        // table write re-services an asserted level pin
        if (upd_hit && trig_lvl && pend_d && !mask) begin
            serve   = 1'b1;
            rpend_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q   <= 1'b0;
            pend_q  <= 1'b0;
            rpend_q <= 1'b0;
            svc_q   <= 1'b0;
            coal_q  <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            raw_q   <= raw;
            pend_q  <= pend_d;
            rpend_q <= rpend_d;
            svc_q   <= (svc_q & ~grant) | serve;
            coal_q  <= coal_d;
            ack_q   <= ack_d;
        end
    end

    assign svc_req    = svc_q;
    assign coal_pulse = coal_q;
    assign ack_pulse  = ack_q;
endmodule

// File: rtl/ire_prio_pick.sv
module ire_prio_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ire_vec_filter.sv
module ire_vec_filter
    import ire_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int VEC_W = 8,
    parameter int PIN_W = 3,
    localparam int FILT = 1 << VEC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rebuild,
    input  logic [NPINS*VEC_W-1:0] tbl_vector,
    output logic [FILT-1:0]    live,
    output flt_state_e         state
);
    localparam logic [PIN_W-1:0] LAST = PIN_W'(NPINS - 1);

    flt_state_e       state_d;
    logic [FILT-1:0]  shadow;
    logic [PIN_W-1:0] idx;
    logic [VEC_W-1:0] cur_vec;

    assign cur_vec = tbl_vector[idx*VEC_W +: VEC_W];

    always_comb begin
        state_d = state;
        unique case (state)
            FLT_WIPE:   state_d = FLT_SCAN;
            FLT_SCAN:   state_d = (idx == LAST) ? FLT_COMMIT : FLT_SCAN;
            FLT_COMMIT: state_d = FLT_IDLE;
            FLT_IDLE:   state_d = FLT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FLT_WIPE;
        end else if (rebuild) begin
            state <= FLT_WIPE;
        end else begin
            state <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '0;
            live   <= '0;
            idx    <= '0;
        end else begin
            unique case (state)
                FLT_WIPE: begin
                    shadow <= '0;
                    idx    <= '0;
                end
                FLT_SCAN: begin
                    shadow[cur_vec] <= 1'b1;
                    idx             <= idx + 1'b1;
                end
                FLT_COMMIT: live <= shadow;
                FLT_IDLE:   ;
            endcase
        end
    end
endmodule

// File: rtl/irq_route_engine.sv
module irq_route_engine
    import ire_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int VEC_W  = 8,
    parameter int DEST_W = 8,
    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1,
    localparam int FILT  = 1 << VEC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPINS-1:0]         pin_raw,
    input  logic [NPINS*VEC_W-1:0]   tbl_vector,
    input  logic [NPINS*DEST_W-1:0]  tbl_dest,
    input  logic [NPINS-1:0]         tbl_dest_mode,
    input  logic [NPINS*DELIV_W-1:0] tbl_deliv,
    input  logic [NPINS-1:0]         tbl_polarity,
    input  logic [NPINS-1:0]         tbl_trig,
    input  logic [NPINS-1:0]         tbl_mask,
    input  logic                     tbl_upd,
    input  logic [PIN_W-1:0]         tbl_upd_pin,
    input  logic                     tbl_upd_low,
    input  logic                     eoi_valid,
    input  logic [VEC_W-1:0]         eoi_vector,
    input  logic                     eoi_level,
    output logic                     dlv_valid,
    output logic [VEC_W-1:0]         dlv_vector,
    output logic [DEST_W-1:0]        dlv_dest,
    output logic                     dlv_dest_mode,
    output logic [DELIV_W-1:0]       dlv_deliv,
    output logic                     dlv_trig,
    output logic [PIN_W-1:0]         dlv_pin,
    output logic [NPINS-1:0]         coalesce_pulse,
    output logic [NPINS-1:0]         ack_pulse
);
    logic [FILT-1:0]    live_filter;
    flt_state_e         flt_state;
    logic               eoi_ok;
    logic [NPINS-1:0]   svc_req;
    logic [NPINS-1:0]   grant;
    logic [PIN_W-1:0]   pick_idx;
    logic               pick_any;

    logic [VEC_W-1:0]   vec_a   [NPINS];
    logic [DEST_W-1:0]  dest_a  [NPINS];
    logic [DELIV_W-1:0] deliv_a [NPINS];

    logic [VEC_W-1:0]   sel_vec;
    logic [DEST_W-1:0]  sel_dest;
    logic [DELIV_W-1:0] sel_deliv;
    logic               sel_dm;
    logic               sel_trig;

    ire_vec_filter #(
        .NPINS(NPINS), .VEC_W(VEC_W), .PIN_W(PIN_W)
    ) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .rebuild    (tbl_upd),
        .tbl_vector (tbl_vector),
        .live       (live_filter),
        .state      (flt_state)
    );

    assign eoi_ok = eoi_valid && live_filter[eoi_vector];

    for (genvar i = 0; i < NPINS; i++) begin : g_lane
        assign vec_a[i]   = tbl_vector[i*VEC_W +: VEC_W];
        assign dest_a[i]  = tbl_dest[i*DEST_W +: DEST_W];
        assign deliv_a[i] = tbl_deliv[i*DELIV_W +: DELIV_W];

        ire_pin_lane #(.VEC_W(VEC_W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw        (pin_raw[i]),
            .pol        (tbl_polarity[i]),
            .trig_lvl   (tbl_trig[i]),
            .mask       (tbl_mask[i]),
            .vec        (vec_a[i]),
            .upd_hit    (tbl_upd && (tbl_upd_pin == PIN_W'(i))),
            .upd_low    (tbl_upd_low),
            .eoi_ok     (eoi_ok),
            .eoi_vec    (eoi_vector),
            .eoi_level  (eoi_level),
            .grant      (grant[i]),
            .svc_req    (svc_req[i]),
            .coal_pulse (coalesce_pulse[i]),
            .ack_pulse  (ack_pulse[i])
        );
    end

    ire_prio_pick #(.N(NPINS), .IDX_W(PIN_W)) u_pick (
        .req   (svc_req),
        .grant (grant),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    always_comb begin
        sel_vec   = '0;
        sel_dest  = '0;
        sel_deliv = '0;
        sel_dm    = 1'b0;
        sel_trig  = 1'b0;
        for (int i = 0; i < NPINS; i++) begin
            if (pick_idx == PIN_W'(i)) begin
                sel_vec   = vec_a[i];
                sel_dest  = dest_a[i];
                sel_deliv = deliv_a[i];
                sel_dm    = tbl_dest_mode[i];
                sel_trig  = tbl_trig[i];
            end
        end
        // pin 0 is pinned to processor 0 in physical mode
        if (pick_idx == '0) begin
            sel_dest = '0;
            sel_dm   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dlv_valid     <= 1'b0;
            dlv_vector    <= '0;
            dlv_dest      <= '0;
            dlv_dest_mode <= 1'b0;
            dlv_deliv     <= '0;
            dlv_trig      <= 1'b0;
            dlv_pin       <= '0;
        end else begin
            dlv_valid <= pick_any;
            if (pick_any) begin
                dlv_vector    <= sel_vec;
                dlv_dest      <= sel_dest;
                dlv_dest_mode <= sel_dm;
                dlv_deliv     <= sel_deliv;
                dlv_trig      <= sel_trig;
                dlv_pin       <= pick_idx;
            end
        end
    end
endmodule

// File: rtl/ire_checker.sv
module ire_checker
    import ire_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int DEST_W = 8,
    parameter int PIN_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dlv_valid,
    input logic [PIN_W-1:0]  dlv_pin,
    input logic [DEST_W-1:0] dlv_dest,
    input logic              dlv_dest_mode,
    input logic [NPINS-1:0]  ack_pulse,
    input logic              eoi_valid,
    input logic [NPINS-1:0]  svc_req,
    input logic [NPINS-1:0]  grant,
    input flt_state_e        flt_state
);
    // R1: reset holds the delivery port quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !dlv_valid);

    // R11: pin 0 always leaves as physical, destination 0
    p_pin0_phys_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_pin == '0) |-> (dlv_dest == '0 && !dlv_dest_mode));

    // R12: at most one pin granted per cycle
    p_grant_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R12: no lower-numbered pin is left waiting behind the grant
    p_lowest_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |-> ((svc_req & (grant - 1'b1)) == '0));

    // R3: every grant becomes a delivery on the next edge, and only a grant
    p_grant_to_dlv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |=> dlv_valid);
    p_no_spurious_dlv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |=> !dlv_valid);

    // R8: ack pulses only follow an EOI strobe
    p_ack_after_eoi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pulse != '0) |-> $past(eoi_valid));

    // R9: the commit state lasts one cycle
    p_commit_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_state == FLT_COMMIT) |=> (flt_state == FLT_IDLE || flt_state == FLT_WIPE));
endmodule

bind irq_route_engine ire_checker #(
    .NPINS(NPINS), .DEST_W(DEST_W), .PIN_W(PIN_W)
) u_ire_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .dlv_valid     (dlv_valid),
    .dlv_pin       (dlv_pin),
    .dlv_dest      (dlv_dest),
    .dlv_dest_mode (dlv_dest_mode),
    .ack_pulse     (ack_pulse),
    .eoi_valid     (eoi_valid),
    .svc_req       (svc_req),
    .grant         (grant),
    .flt_state     (flt_state)
);

// File: tb/tb_irq_route_engine.sv
`timescale 1ns/1ps
module tb_irq_route_engine;
    localparam int NP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NP-1:0] raw = '0;
    logic [NP*8-1:0] f_vec, f_dst;
    logic [NP-1:0] f_dm, f_pol, f_lvl, f_msk;
    logic [NP*3-1:0] f_dl;
    logic        tbl_upd = 1'b0;
    logic [2:0]  tbl_upd_pin = '0;
    logic        tbl_upd_low = 1'b0;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        eoi_level = 1'b0;

    logic        dlv_valid;
    logic [7:0]  dlv_vector, dlv_dest;
    logic        dlv_dest_mode, dlv_trig;
    logic [2:0]  dlv_deliv, dlv_pin;
    logic [NP-1:0] coalesce_pulse, ack_pulse;

    logic [7:0] t_vec [NP];
    logic [7:0] t_dst [NP];
    logic [2:0] t_dl  [NP];
    logic       t_dm  [NP];
    logic       t_pol [NP];
    logic       t_lvl [NP];
    logic       t_msk [NP];

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            f_vec[i*8 +: 8] = t_vec[i];
            f_dst[i*8 +: 8] = t_dst[i];
            f_dl[i*3 +: 3]  = t_dl[i];
            f_dm[i]  = t_dm[i];
            f_pol[i] = t_pol[i];
            f_lvl[i] = t_lvl[i];
            f_msk[i] = t_msk[i];
        end
    end

    irq_route_engine dut (
        .clk(clk), .rst_n(rst_n), .pin_raw(raw),
        .tbl_vector(f_vec), .tbl_dest(f_dst), .tbl_dest_mode(f_dm),
        .tbl_deliv(f_dl), .tbl_polarity(f_pol), .tbl_trig(f_lvl), .tbl_mask(f_msk),
        .tbl_upd(tbl_upd), .tbl_upd_pin(tbl_upd_pin), .tbl_upd_low(tbl_upd_low),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level),
        .dlv_valid(dlv_valid), .dlv_vector(dlv_vector), .dlv_dest(dlv_dest),
        .dlv_dest_mode(dlv_dest_mode), .dlv_deliv(dlv_deliv), .dlv_trig(dlv_trig),
        .dlv_pin(dlv_pin), .coalesce_pulse(coalesce_pulse), .ack_pulse(ack_pulse)
    );

    int checks = 0;
    int fails  = 0;
    int dcount = 0;
    int ccount = 0;
    int acount = 0;
    int dseq [64];

    // output monitor, exactly on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (dlv_valid) begin
                dseq[dcount % 64] = int'(dlv_pin);
                dcount++;
            end
            ccount += $countones(coalesce_pulse);
            acount += $countones(ack_pulse);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic set_entry(input int p, input logic [7:0] v, input logic [7:0] d,
                             input logic dm, input logic [2:0] dl, input logic pol,
                             input logic lvl, input logic msk, input logic low);
        t_vec[p] = v; t_dst[p] = d; t_dm[p] = dm; t_dl[p] = dl;
        t_pol[p] = pol; t_lvl[p] = lvl; t_msk[p] = msk;
        tbl_upd = 1'b1; tbl_upd_pin = 3'(p); tbl_upd_low = low;
        tick(1);
        tbl_upd = 1'b0; tbl_upd_low = 1'b0;
        tick(20);
    endtask

    task automatic eoi(input logic [7:0] v, input logic lvl);
        eoi_valid = 1'b1; eoi_vector = v; eoi_level = lvl;
        tick(1);
        eoi_valid = 1'b0;
        tick(4);
    endtask

    typedef struct packed {
        logic [2:0] pin;
        logic       pol;
        logic       lvl;
        logic       msk;
        logic [7:0] vec;
        logic [7:0] dst;
        logic       dm;
        logic [2:0] dl;
        logic       exp;
    } row_t;

    localparam row_t ROWS [0:5] = '{
        '{3'd2, 1'b0, 1'b0, 1'b0, 8'h41, 8'h12, 1'b1, 3'd0, 1'b1},
        '{3'd2, 1'b1, 1'b0, 1'b0, 8'h42, 8'h13, 1'b0, 3'd1, 1'b1},
        '{3'd3, 1'b0, 1'b1, 1'b0, 8'h43, 8'h05, 1'b1, 3'd2, 1'b1},
        '{3'd3, 1'b1, 1'b1, 1'b1, 8'h44, 8'h06, 1'b0, 3'd4, 1'b0},
        '{3'd0, 1'b0, 1'b0, 1'b0, 8'h50, 8'h09, 1'b1, 3'd0, 1'b1},
        '{3'd7, 1'b1, 1'b0, 1'b1, 8'h57, 8'h0a, 1'b1, 3'd5, 1'b0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R1-wide run actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int base, cbase, abase;
        row_t r;
        for (int i = 0; i < NP; i++) begin
            t_vec[i] = 8'(8'h20 + i); t_dst[i] = '0; t_dl[i] = '0; t_dm[i] = 1'b0;
            t_pol[i] = 1'b0; t_lvl[i] = 1'b0; t_msk[i] = 1'b1;
        end
        tick(3);
        // R1: quiet during reset
        chk(!dlv_valid && coalesce_pulse == '0 && ack_pulse == '0, "R1 reset outputs",
            int'(dlv_valid), 0);
        rst_n = 1'b1;
        tick(20);
        chk(dcount == 0 && ccount == 0 && acount == 0, "R1 quiet after reset", dcount, 0);

        // vector table walk: R2 polarity, R3 fields/latency, R5 mask, R11 pin 0
        for (int k = 0; k < 6; k++) begin
            r = ROWS[k];
            set_entry(int'(r.pin), r.vec, r.dst, r.dm, r.dl, r.pol, r.lvl, r.msk, 1'b1);
            raw[r.pin] = r.pol;
            tick(3);
            base = dcount; cbase = ccount;
            raw[r.pin] = ~r.pol;
            tick(2);
            chk(dlv_valid == r.exp, "R3 delivery timing / R5 mask", int'(dlv_valid), int'(r.exp));
            if (r.exp) begin
                chk(dlv_vector == r.vec && dlv_deliv == r.dl && dlv_pin == r.pin &&
                    dlv_trig == r.lvl, "R3 delivered fields", int'(dlv_vector), int'(r.vec));
                if (r.pin == 3'd0)
                    chk(dlv_dest == 8'h00 && !dlv_dest_mode, "R11 pin 0 physical", int'(dlv_dest), 0);
                else
                    chk(dlv_dest == r.dst && dlv_dest_mode == r.dm, "R2 R3 destination",
                        int'(dlv_dest), int'(r.dst));
            end
            tick(3);
            chk(dcount - base == int'(r.exp) && ccount == cbase, "R5 delivery count",
                dcount - base, int'(r.exp));
            raw[r.pin] = r.pol;
            tick(3);
            if (r.lvl) eoi(r.vec, 1'b1);
            tick(3);
        end

        // R5 / R10: masked level pin, then unmask by low-half write
        set_entry(4, 8'h64, 8'h01, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1);
        base = dcount; cbase = ccount;
        raw[4] = 1'b1; tick(5);
        chk(dcount == base && ccount == cbase, "R5 masked level pin silent", dcount - base, 0);
        set_entry(4, 8'h64, 8'h01, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk(dcount - base == 1 && dseq[base % 64] == 4, "R10 low write services pin", dcount - base, 1);
        base = dcount;
        set_entry(4, 8'h64, 8'h01, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk(dcount - base == 1, "R10 high write services pending level pin", dcount - base, 1);

        // R4 / R13: remote-pending blocks re-service and reports coalesced
        base = dcount; cbase = ccount;
        raw[4] = 1'b0; tick(3); raw[4] = 1'b1; tick(5);
        chk(dcount == base, "R4 no delivery while remote pending", dcount - base, 0);
        chk(ccount - cbase == 1, "R13 level coalesced pulse", ccount - cbase, 1);

        // R7 / R8: edge-mode EOI acks but keeps remote-pending
        base = dcount; cbase = ccount; abase = acount;
        eoi(8'h64, 1'b0);
        chk(acount - abase == 1 && dcount == base, "R7 R8 edge EOI ack only", acount - abase, 1);
        raw[4] = 1'b0; tick(3); raw[4] = 1'b1; tick(5);
        chk(ccount - cbase == 1 && dcount == base, "R7 remote pending kept", ccount - cbase, 1);

        // R6: level EOI re-delivers the still asserted pin
        base = dcount; abase = acount;
        eoi(8'h64, 1'b1);
        chk(dcount - base == 1 && dseq[base % 64] == 4, "R6 level EOI re-delivery", dcount - base, 1);
        chk(acount - abase == 1, "R8 ack on level EOI", acount - abase, 1);

        // R9: unprogrammed vector is ignored
        base = dcount; cbase = ccount; abase = acount;
        eoi(8'h99, 1'b1);
        chk(acount == abase && dcount == base, "R9 filtered EOI no ack", acount - abase, 0);
        raw[4] = 1'b0; tick(3); raw[4] = 1'b1; tick(5);
        chk(ccount - cbase == 1 && dcount == base, "R9 remote pending untouched", ccount - cbase, 1);
        raw[4] = 1'b0; tick(3);
        base = dcount;
        eoi(8'h64, 1'b1);
        chk(dcount == base, "R6 no re-delivery when not pending", dcount - base, 0);

        // R13: edge pin with pending already set
        set_entry(1, 8'h31, 8'h02, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        base = dcount; cbase = ccount;
        raw[1] = 1'b1; tick(5);
        chk(dcount - base == 1, "R3 edge pin delivered", dcount - base, 1);
        set_entry(1, 8'h31, 8'h02, 1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1);
        base = dcount;
        raw[1] = 1'b0; tick(5);
        chk(ccount - cbase == 1 && dcount == base, "R13 edge coalesced", ccount - cbase, 1);

        // R12: simultaneous requests, lowest pin first, one per cycle
        set_entry(5, 8'h65, 8'h03, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        set_entry(2, 8'h62, 8'h03, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        set_entry(6, 8'h66, 8'h03, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        raw[2] = 1'b0; tick(3);
        base = dcount;
        raw[2] = 1'b1; raw[5] = 1'b1; raw[6] = 1'b1;
        tick(2);
        chk(dlv_valid && dlv_pin == 3'd2, "R12 first grant pin 2", int'(dlv_pin), 2);
        tick(1);
        chk(dlv_valid && dlv_pin == 3'd5, "R12 second grant pin 5", int'(dlv_pin), 5);
        tick(1);
        chk(dlv_valid && dlv_pin == 3'd6, "R12 third grant pin 6", int'(dlv_pin), 6);
        tick(3);
        chk(dcount - base == 3, "R12 exactly three deliveries", dcount - base, 3);

        // R8: one EOI acks every matching entry
        set_entry(5, 8'h70, 8'h03, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        set_entry(6, 8'h70, 8'h03, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1);
        abase = acount;
        eoi(8'h70, 1'b0);
        chk(acount - abase == 2, "R8 two matching entries acked", acount - abase, 2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule